// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Receiver

This block turns an asynchronous serial stream back into a parallel character. It watches an idle-high line for a falling edge. It confirms the start bit half a bit later, then samples every data, parity and stop bit at the centre of its bit cell. Timing is taken from a baud enable that pulses sixteen times per bit period.

The frame format comes from a six-bit control field that the transmitter side also uses. That field sets the character length (5 to 8 bits) and whether a parity bit is present. It also sets how the parity bit is judged: odd, even, fixed at one or fixed at zero. The control value is captured once the start bit is confirmed, so a change in the middle of a frame only affects later frames.

Each finished character is presented with a one-clock valid strobe. Two error flags, parity and framing, are valid in the same cycle and keep their values until the next character finishes.

Top module: `uart_frame_rx`

## Requirements
- R1: The character length follows ctrl[1:0]: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits arrive least significant first, and rx_data bits above the length read zero.
- R2: With ctrl[3]=0 no parity bit is taken from the line; the stop bit follows the last data bit directly, and par_err is 0 for that character.
- R3: With ctrl[3]=1 and ctrl[5]=0, ctrl[4]=0 demands an odd number of ones across data plus parity bit, and ctrl[4]=1 demands an even number; a mismatch sets par_err.
- R4: With ctrl[3]=1 and ctrl[5]=1, the parity bit must be 1 when ctrl[4]=0 and 0 when ctrl[4]=1; any other value sets par_err.
- R5: A frame begins only on a high-to-low change of the line. The line is checked again 8 ticks later, and if it is high the start is dropped and no character is produced.
- R6: After the start check, each later bit is sampled exactly 16 ticks after the previous sample; ticks are the only thing that advances bit timing.
- R7: Only the first stop bit is examined; if it is sampled low, frm_err is set for that character.
- R8: rx_valid is high for exactly one clock per character. rx_data, par_err and frm_err are valid in that cycle and hold until the next character completes.
- R9: After the stop-bit sample the receiver hunts for a new start, and a line that stays low after a bad stop bit does not start another frame until it has been high.
- R10: The control field is captured when the start bit is confirmed; changing ctrl during the frame does not alter how that frame is decoded. ctrl[7:6] and ctrl[2] have no effect on reception.
- R11: While rst_n is low and after it is released, rx_valid, rx_data, par_err and frm_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-clock enable, sixteen per bit period |
| ctrl | input | 8 | Frame format control field |
| rxd | input | 1 | Serial line, idle high |
| rx_data | output | 8 | Received character, right aligned, upper bits zero |
| rx_valid | output | 1 | One-clock strobe for a finished character |
| par_err | output | 1 | Parity check failed on the last character |
| frm_err | output | 1 | Stop bit was low on the last character |

## Verification
The hardest state to reach is a framing error where the line stays low after the stop sample. In that case the receiver must not treat the held-low level as a new start edge. The bench drives a frame with a low stop bit and keeps the line low for two more bit times before it lets the line go high. It then counts valid strobes and checks the next character. Two other cases need directed timing: a short low pulse that drops before the half-bit check, and a control change applied after the start bit is confirmed. These sit next to random frames whose parity and stop bits are corrupted on purpose.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes the control field layout: [5] fixed parity, [4] even / fixed-zero,
// [3] parity present, [2] stop length (ignored on receive), [1:0] length.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic       par_fixed;
        logic       par_sel;
        logic       par_on;
        logic       stop_len;
        logic [1:0] len_code;
    } rx_cfg_t;

    // Number of data bits for a length code (5..8).
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
// Brings the asynchronous serial line into the clock domain.
// Assumes the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_deser.sv
// Collects data bits least significant first and right-aligns the result.
// Assumes the caller clears it before a frame and shifts exactly nbits times.
module rx_deser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic [3:0]        nbits,
    output logic [DATA_W-1:0] word
);
    localparam logic [3:0] FULL = 4'(DATA_W);

    logic [DATA_W-1:0] sh;
    logic [3:0]        shamt;

    // Shift a new bit in at the top so the first bit ends lowest.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sh <= '0;
        else if (shift_en)   sh <= {bit_in, sh[DATA_W-1:1]};
    end

    // Drop the unused low positions so bit 0 is the first received bit.
    always_comb begin
        shamt = FULL - nbits;
        word  = sh >> shamt;
    end
endmodule

// File: rtl/rx_parity_chk.sv
// Judges the received parity bit against the selected rule.
// Assumes unused upper data bits are zero; result only matters with parity on.
module rx_parity_chk #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]     data,
    input  logic                  pbit,
    input  uart_rx_pkg::rx_cfg_t  cfg,
    output logic                  bad
);
    logic ones_odd;

    // Select between the counting rules and the fixed-level rules.
    always_comb begin
        ones_odd = ^{data, pbit};
        if (cfg.par_fixed) bad = (pbit == cfg.par_sel);
        else if (cfg.par_sel) bad = ones_odd;
        else bad = ~ones_odd;
    end
endmodule

// File: rtl/uart_frame_rx.sv
// Asynchronous serial receiver with programmable length and parity rule.
// Assumes baud_tick pulses OVERSAMPLE times per bit and DATA_W is 8.
module uart_frame_rx #(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [7:0]        ctrl,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              par_err,
    output logic              frm_err
);
    import uart_rx_pkg::*;

    localparam int              CNT_W    = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  tick_cnt;
    logic [3:0]        bit_cnt;
    rx_cfg_t           cfg_q;
    logic              armed;
    logic              pbit_q;
    logic              line;
    logic              samp_mid;
    logic              samp_bit;
    logic              shift_en;
    logic [3:0]        nbits;
    logic [DATA_W-1:0] word;
    logic              par_bad;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line)
    );

    rx_deser #(.DATA_W(DATA_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_START),
        .shift_en(shift_en),
        .bit_in  (line),
        .nbits   (nbits),
        .word    (word)
    );

    rx_parity_chk #(.DATA_W(DATA_W)) u_par (
        .data(word),
        .pbit(pbit_q),
        .cfg (cfg_q),
        .bad (par_bad)
    );

    // Sample strobes at half-bit (start) and full-bit (later bits).
    always_comb begin
        samp_mid = baud_tick && (tick_cnt == MID_LAST);
        samp_bit = baud_tick && (tick_cnt == BIT_LAST);
        shift_en = (state == ST_DATA) && samp_bit;
        nbits    = word_bits(cfg_q.len_code);
    end

    // Frame sequencer: hunt, confirm start, collect bits, judge stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            cfg_q    <= '0;
            armed    <= 1'b0;
            pbit_q   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (baud_tick && state != ST_IDLE) tick_cnt <= tick_cnt + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    tick_cnt <= '0;
                    if (baud_tick) begin
                        if (line) armed <= 1'b1;
                        else if (armed) state <= ST_START;
                    end
                end
                ST_START: begin
                    if (samp_mid) begin
                        tick_cnt <= '0;
                        bit_cnt  <= '0;
                        if (line) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_DATA;
                            cfg_q <= rx_cfg_t'(ctrl[5:0]);
                        end
                    end
                end
                ST_DATA: begin
                    if (samp_bit) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == nbits - 4'd1)
                            state <= cfg_q.par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (samp_bit) begin
                        pbit_q <= line;
                        state  <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (samp_bit) begin
                        rx_valid <= 1'b1;
                        rx_data  <= word;
                        par_err  <= cfg_q.par_on & par_bad;
                        frm_err  <= ~line;
                        armed    <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the strobe never lasts two clocks.
    a_r8_valid_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: flags only change alongside a strobe.
    a_r8_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(par_err) && $stable(frm_err) && $stable(rx_data)));

    // R2: no parity error for a frame decoded without parity.
    a_r2_no_par_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && samp_bit && !cfg_q.par_on) |=> !par_err);

    // R1: a five-bit character leaves the upper bits clear.
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && samp_bit && cfg_q.len_code == 2'b00) |=> (rx_data[DATA_W-1:5] == '0));

    // R5: a high line at the half-bit check drops the frame.
    a_r5_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && samp_mid && line) |=> (state == ST_IDLE));

    // R9: after the stop sample the sequencer is hunting again.
    a_r9_back_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && samp_bit) |=> (state == ST_IDLE && !armed));

    // R10: captured format is frozen for the rest of the frame.
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_DATA, ST_PAR, ST_STOP} && $past(state) inside {ST_DATA, ST_PAR, ST_STOP})
        |-> $stable(cfg_q));

    // R6: without a tick the bit timer holds.
    a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && state inside {ST_DATA, ST_PAR, ST_STOP}) |=> $stable(tick_cnt));
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] ctrl = 8'h03;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       par_err;
    logic       frm_err;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int wide = 0;
    logic prev_v = 1'b0;
    logic [7:0] cap_data;
    logic cap_pe, cap_fe;

    always #2 clk = ~clk;

    uart_frame_rx u_uart_frame_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ctrl(ctrl), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
    );

    // Tick generator: one pulse every TICK_DIV clocks, driven on the falling edge.
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n = (n + 1) % TICK_DIV;
            baud_tick = (n == 0);
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            pulses++;
            cap_data = rx_data;
            cap_pe = par_err;
            cap_fe = frm_err;
            if (prev_v) wide++;
        end
        prev_v = rx_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic [7:0] mask_of(input logic [7:0] c, input logic [7:0] d);
        return d & ((8'd1 << nbits_of(c)) - 8'd1);
    endfunction

    // Correct parity bit for a character under a control value.
    function automatic logic good_parity(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] m;
        m = mask_of(c, d);
        if (c[5]) return ~c[4];
        if (c[4]) return ^m;
        return ~^m;
    endfunction

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Send one frame; ctrl may be swapped to c_mid after the first data bit.
    task automatic send_frame(input logic [7:0] d, input logic [7:0] c, input logic bad_par,
                              input logic stop_v, input logic [7:0] c_mid, input int gap);
        int nb;
        ctrl = c;
        nb = nbits_of(c);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            hold_bit(d[i]);
            if (i == 0) ctrl = c_mid;
        end
        if (c[3]) hold_bit(good_parity(c, d) ^ bad_par);
        hold_bit(stop_v);
        for (int i = 0; i < gap; i++) hold_bit(1'b1);
    endtask

    task automatic frame_and_check(input logic [7:0] d, input logic [7:0] c, input logic bad_par,
                                   input logic stop_v, input logic [7:0] c_mid, input string tag);
        logic [7:0] exp_d;
        logic exp_pe;
        pulses = 0;
        wide = 0;
        send_frame(d, c, bad_par, stop_v, c_mid, 1);
        exp_d = mask_of(c, d);
        exp_pe = c[3] & bad_par;
        check(pulses == 1, {tag, " R8 strobe count"}, pulses, 1);
        check(wide == 0, {tag, " R8 strobe width"}, wide, 0);
        check(cap_data == exp_d, {tag, " R1 data"}, cap_data, exp_d);
        check(cap_pe == exp_pe, {tag, " R3/R4 parity flag"}, cap_pe, exp_pe);
        check(cap_fe == ~stop_v, {tag, " R7 framing flag"}, cap_fe, ~stop_v);
        check(par_err == exp_pe && frm_err == ~stop_v, {tag, " R8 flags held"},
              {par_err, frm_err}, {exp_pe, ~stop_v});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        check(rx_valid == 0 && rx_data == 0 && par_err == 0 && frm_err == 0,
              "R11 reset state", {rx_valid, rx_data, par_err, frm_err}, 0);
        rst_n = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        check(rx_valid == 0 && rx_data == 0, "R11 after release", rx_data, 0);

        // R1 lengths, no parity (R2), ignored bits 7:6 and 2 (R10)
        frame_and_check(8'hFF, 8'b1100_0100, 0, 1, 8'b1100_0100, "R1 len5");
        frame_and_check(8'hA5, 8'b0000_0001, 0, 1, 8'b0000_0001, "R1 len6");
        frame_and_check(8'h5A, 8'b0000_0010, 0, 1, 8'b0000_0010, "R1 len7");
        frame_and_check(8'h81, 8'b0000_0111, 0, 1, 8'b0000_0111, "R2 len8 noparity R10");
        // R3 odd and even, good and bad
        frame_and_check(8'h37, 8'b0000_1011, 0, 1, 8'b0000_1011, "R3 odd good");
        frame_and_check(8'h37, 8'b0000_1011, 1, 1, 8'b0000_1011, "R3 odd bad");
        frame_and_check(8'h37, 8'b0001_1011, 1, 1, 8'b0001_1011, "R3 even bad");
        // R4 fixed one / fixed zero
        frame_and_check(8'h00, 8'b0010_1011, 0, 1, 8'b0010_1011, "R4 fixed1 good");
        frame_and_check(8'h00, 8'b0010_1011, 1, 1, 8'b0010_1011, "R4 fixed1 bad");
        frame_and_check(8'hFF, 8'b0011_1011, 1, 1, 8'b0011_1011, "R4 fixed0 bad");
        // R10: format change after the first data bit has no effect
        frame_and_check(8'hC3, 8'b0000_1011, 0, 1, 8'b0011_0000, "R10 mid change");

        // R5: short low pulse, gone before the half-bit check
        pulses = 0;
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (20 * BIT_CLKS) @(negedge clk);
        check(pulses == 0, "R5 false start dropped", pulses, 0);

        // R7/R9: bad stop, line held low, then a normal frame
        pulses = 0;
        send_frame(8'h55, 8'h03, 0, 0, 8'h03, 0);
        hold_bit(1'b0);
        hold_bit(1'b0);
        hold_bit(1'b1);
        check(pulses == 1 && cap_fe == 1, "R9 no restart on held low", pulses, 1);
        frame_and_check(8'h6E, 8'h0B, 0, 1, 8'h0B, "R9 recovery");

        // R6 and all requirements: random formats, data and corruptions
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d, c;
            logic bp, sv;
            d = 8'($urandom);
            c = 8'($urandom);
            bp = 1'($urandom);
            sv = ($urandom % 5) != 0;
            frame_and_check(d, c, bp, sv, c, "R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule